// File: doc/BRIEF.md
# Multiplexed-Bus Memory and I/O Front End

This block sits between an 8-bit processor bus that carries address and data on the same wires and a peripheral that holds a 256-byte static memory plus a small register space. Address, enable and space select are taken in once per bus cycle, when the address strobe falls. The active-low read and write strobes that follow then reach either the memory or the register space. The enable level seen at strobe time plays no part in that choice. All bus inputs are sampled on the block clock.

The register space holds a command register, two 8-bit ports and one narrower port. It also holds two slots that belong to a counter/timer kept outside this block. Status and timer contents arrive on an input and leave through a registered write pulse, so the handshake and timer logic can live elsewhere. The command register sets each port's direction, and reset returns every port to input.

Top module: `mux_bus_ram_io`

## Requirements
- R1: Address, enable state and space select are captured at the first clock edge at which `ale` is sampled low after being sampled high. They do not change at any other edge.
- R2: With `io_m` captured as 0, a write is committed at the clock edge where `wr_n` is first sampled high after being low. It stores `ad_in` as sampled at that same edge into the memory byte at the captured address.
- R3: With `io_m` captured as 0 and the captured enable true, holding `rd_n` low for two clock edges makes `ad_out` show the stored byte at the captured address, with `ad_oe` high.
- R4: `ad_oe` is high only in the cycle after an edge at which `rd_n` was low, the captured enable was true and `rst` was low.
- R5: Changes on `ce_pin` after the capture have no effect. A cycle captured as enabled completes its read or write, and a cycle captured as disabled neither writes nor drives the bus.
- R6: I/O space with `io_m` captured as 1 decodes the full captured address. Address 0 is command on write and reads `ext_rd_data`; 1 is port A, 2 is port B and 3 is port C; 4 and 5 are timer slots that read `ext_rd_data`. A write to 0, 4 or 5 raises `ext_wr` for exactly one cycle, carrying the written byte on `ext_wdata`. I/O writes never alter memory.
- R7: I/O addresses 6 and above read as 0x00, and writes to them change no port, direction or command and raise no `ext_wr`.
- R8: Command bit 0 set drives `pa_oe` all ones and bit 1 does the same for `pb_oe`. Bits 3:2 equal to 2'b11 drive all of `pc_oe` high; any other value of bits 3:2 leaves port C as input.
- R9: A port read returns the port's output register when that port is an output, and the sampled port input pins when it is an input. Port C is zero-extended to 8 bits.
- R10: `rst` high clears the command register and the port output registers. All three ports become inputs and `ad_oe` goes low.
- R11: Parameter `CE_ACTIVE_HIGH` selects the enable level. At 0, `ce_pin` low enables; at 1, `ce_pin` high enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address strobe; capture on its falling edge |
| ce_pin | input | 1 | Chip enable, level set by CE_ACTIVE_HIGH |
| io_m | input | 1 | Space select: 0 memory, 1 registers |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ad_in | input | 8 | Bus value seen by the block |
| ad_out | output | 8 | Bus value driven by the block |
| ad_oe | output | 1 | Bus driver enable |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A output register |
| pa_oe | output | 8 | Port A driver enable |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B output register |
| pb_oe | output | 8 | Port B driver enable |
| pc_in | input | 6 | Port C pins in |
| pc_out | output | 6 | Port C output register |
| pc_oe | output | 6 | Port C driver enable |
| ext_rd_data | input | 8 | Status or timer byte for addresses 0, 4, 5 |
| ext_addr | output | 3 | Low bits of the captured address |
| ext_wr | output | 1 | One-cycle write pulse for addresses 0, 4, 5 |
| ext_wdata | output | 8 | Byte carried with ext_wr |
| ctrl_word | output | 8 | Current command register |

## Verification
The bench builds the block with 8 address bits, so every byte of the 256-byte memory is reachable, including both ends of the range. It uses 6 port C pins and the active-low enable (`CE_ACTIVE_HIGH` = 0). With that build, an enable pin that flips between capture and strobe exercises both the captured-enabled and captured-disabled cases. The full-width decode lets addresses such as 0x40 check that unused I/O space is really ignored.

// File: rtl/mbio_pkg.sv
package mbio_pkg;
  // I/O space decode values (low address bits); neighbours decode these
  localparam logic [2:0] IO_CMD = 3'd0;
  localparam logic [2:0] IO_PA  = 3'd1;
  localparam logic [2:0] IO_PB  = 3'd2;
  localparam logic [2:0] IO_PC  = 3'd3;
  localparam logic [2:0] IO_T0  = 3'd4;
  localparam logic [2:0] IO_T1  = 3'd5;
  localparam int         IO_LAST = 5;

  // command register fields
  localparam int         CMD_C_LO   = 2;
  localparam int         CMD_C_HI   = 3;
  localparam logic [1:0] C_MODE_OUT = 2'b11;
endpackage

// File: rtl/mbio_bus_latch.sv
module mbio_bus_latch #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter bit CE_ACTIVE_HIGH = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              ce_pin,
  input  logic              io_m,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              cap_en,
  output logic              cap_io,
  output logic              rd_act,
  output logic              wr_commit
);
  logic ale_q;
  logic wr_q;
  logic ce_on;

  assign ce_on = CE_ACTIVE_HIGH ? ce_pin : ~ce_pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q    <= 1'b0;
      wr_q     <= 1'b1;
      cap_addr <= '0;
      cap_en   <= 1'b0;
      cap_io   <= 1'b0;
    end else begin
      ale_q <= ale;
      wr_q  <= wr_n;
      if (ale_q && !ale) begin
        cap_addr <= ad_in[ADDR_W-1:0];
        cap_en   <= ce_on;
        cap_io   <= io_m;
      end
    end
  end

  // strobes are qualified by the captured enable, never the live pin
  assign rd_act    = !rd_n && cap_en && !rst;
  assign wr_commit = !wr_q && wr_n && cap_en && !rst;
endmodule

// File: rtl/mbio_ram.sv
module mbio_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/mbio_io_regs.sv
module mbio_io_regs
  import mbio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PC_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pa_in,
  input  logic [DATA_W-1:0] pb_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DATA_W-1:0] ext_rd_data,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] pa_out,
  output logic [DATA_W-1:0] pa_oe,
  output logic [DATA_W-1:0] pb_out,
  output logic [DATA_W-1:0] pb_oe,
  output logic [PC_W-1:0]   pc_out,
  output logic [PC_W-1:0]   pc_oe,
  output logic [DATA_W-1:0] ctrl_word,
  output logic              ext_wr,
  output logic [DATA_W-1:0] ext_wdata
);
  localparam int NPORT = 2;

  logic [DATA_W-1:0]             cmd_q;
  logic [PC_W-1:0]               pc_q;
  logic [2:0]                    sel;
  logic                          valid;
  logic                          pc_dir;
  logic [PC_W-1:0]               pc_rd;
  logic [NPORT-1:0][DATA_W-1:0]  p_in;
  logic [NPORT-1:0][DATA_W-1:0]  p_rd;
  logic [NPORT-1:0][DATA_W-1:0]  p_out;
  logic [NPORT-1:0][DATA_W-1:0]  p_oe;

  assign sel    = addr[2:0];
  assign valid  = (addr <= ADDR_W'(IO_LAST));
  assign pc_dir = (cmd_q[CMD_C_HI:CMD_C_LO] == C_MODE_OUT);
  assign pc_rd  = pc_dir ? pc_q : pc_in;
  assign p_in   = {pb_in, pa_in};

  // the two full-width ports share one structure
  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (wr_en && valid && sel == 3'(int'(IO_PA) + g)) q <= wdata;
    end
    assign p_rd[g]  = cmd_q[g] ? q : p_in[g];
    assign p_out[g] = q;
    assign p_oe[g]  = {DATA_W{cmd_q[g]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      pc_q      <= '0;
      ext_wr    <= 1'b0;
      ext_wdata <= '0;
      rdata     <= '0;
    end else begin
      ext_wr <= 1'b0;
      if (wr_en && valid) begin
        if (sel == IO_CMD) cmd_q <= wdata;
        if (sel == IO_PC)  pc_q  <= wdata[PC_W-1:0];
        if (sel == IO_CMD || sel == IO_T0 || sel == IO_T1) begin
          ext_wr    <= 1'b1;
          ext_wdata <= wdata;
        end
      end
      if (!valid) rdata <= '0;
      else begin
        case (sel)
          IO_CMD, IO_T0, IO_T1: rdata <= ext_rd_data;
          IO_PA:                rdata <= p_rd[0];
          IO_PB:                rdata <= p_rd[1];
          IO_PC:                rdata <= DATA_W'(pc_rd);
          default:              rdata <= '0;
        endcase
      end
    end
  end

  assign pa_out    = p_out[0];
  assign pa_oe     = p_oe[0];
  assign pb_out    = p_out[1];
  assign pb_oe     = p_oe[1];
  assign pc_out    = pc_q;
  assign pc_oe     = {PC_W{pc_dir}};
  assign ctrl_word = cmd_q;
endmodule

// File: rtl/mux_bus_ram_io.sv
module mux_bus_ram_io #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PC_W   = 6,
  parameter bit CE_ACTIVE_HIGH = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              ce_pin,
  input  logic              io_m,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] pa_in,
  output logic [DATA_W-1:0] pa_out,
  output logic [DATA_W-1:0] pa_oe,
  input  logic [DATA_W-1:0] pb_in,
  output logic [DATA_W-1:0] pb_out,
  output logic [DATA_W-1:0] pb_oe,
  input  logic [PC_W-1:0]   pc_in,
  output logic [PC_W-1:0]   pc_out,
  output logic [PC_W-1:0]   pc_oe,
  input  logic [DATA_W-1:0] ext_rd_data,
  output logic [2:0]        ext_addr,
  output logic              ext_wr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic [DATA_W-1:0] ctrl_word
);
  logic [ADDR_W-1:0] cap_addr;
  logic              cap_en;
  logic              cap_io;
  logic              rd_act;
  logic              wr_commit;
  logic [DATA_W-1:0] ram_rd;
  logic [DATA_W-1:0] io_rd;
  logic              io_sel_d;

  mbio_bus_latch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CE_ACTIVE_HIGH(CE_ACTIVE_HIGH)
  ) u_latch (
    .clk(clk), .rst(rst), .ale(ale), .ce_pin(ce_pin), .io_m(io_m),
    .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in),
    .cap_addr(cap_addr), .cap_en(cap_en), .cap_io(cap_io),
    .rd_act(rd_act), .wr_commit(wr_commit)
  );

  mbio_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(wr_commit && !cap_io), .addr(cap_addr),
    .wdata(ad_in), .rdata(ram_rd)
  );

  mbio_io_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_W(PC_W)) u_io (
    .clk(clk), .rst(rst), .wr_en(wr_commit && cap_io), .addr(cap_addr),
    .wdata(ad_in), .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in),
    .ext_rd_data(ext_rd_data), .rdata(io_rd),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_out(pc_out), .pc_oe(pc_oe), .ctrl_word(ctrl_word),
    .ext_wr(ext_wr), .ext_wdata(ext_wdata)
  );

  // align the space select with the registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      io_sel_d <= 1'b0;
      ad_oe    <= 1'b0;
    end else begin
      io_sel_d <= cap_io;
      ad_oe    <= rd_act;
    end
  end

  assign ad_out   = io_sel_d ? io_rd : ram_rd;
  assign ext_addr = cap_addr[2:0];
endmodule

// File: rtl/mbio_checker.sv
module mbio_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PC_W   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              ale,
  input logic              rd_n,
  input logic              wr_n,
  input logic              ad_oe,
  input logic              cap_en,
  input logic [ADDR_W-1:0] cap_addr,
  input logic [DATA_W-1:0] pa_oe,
  input logic [DATA_W-1:0] pb_oe,
  input logic [PC_W-1:0]   pc_oe,
  input logic              ext_wr
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_addr_on_ale_fall_r1: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2 && !$stable(cap_addr)) |-> ($past(ale, 2) && !$past(ale, 1)));

  p_oe_qualified_r4: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2 && ad_oe) |-> ($past(!rd_n) && $past(cap_en)));

  p_dir_needs_write_r8: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2 && !$stable(pa_oe)) |-> (!$past(wr_n, 2) && $past(wr_n, 1)));

  p_inputs_after_reset_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0));

  p_ext_wr_single_r6: assert property (@(posedge clk) disable iff (rst)
    ext_wr |=> !ext_wr);
endmodule

bind mux_bus_ram_io mbio_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_W(PC_W)
) u_chk (
  .clk(clk), .rst(rst), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .ad_oe(ad_oe), .cap_en(cap_en), .cap_addr(cap_addr),
  .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe), .ext_wr(ext_wr)
);

// File: tb/mux_bus_ram_io_tb.sv
module mux_bus_ram_io_tb;
  localparam bit CE_HI = 1'b0;
  localparam logic CE_ON  = CE_HI ? 1'b1 : 1'b0;
  localparam logic CE_OFF = ~CE_ON;

  logic clk = 0, rst = 1, ale = 0, ce_pin = CE_OFF, io_m = 0, rd_n = 1, wr_n = 1;
  logic [7:0] ad_in = 0, pa_in = 0, pb_in = 0, ext_rd_data;
  logic [5:0] pc_in = 0;
  logic [7:0] ad_out, pa_out, pa_oe, pb_out, pb_oe, ext_wdata, ctrl_word;
  logic [5:0] pc_out, pc_oe;
  logic [2:0] ext_addr;
  logic ad_oe, ext_wr;

  int checks = 0, errors = 0;
  logic [7:0] model [256];
  bit known [256];
  logic [7:0] rv; logic roe;
  logic last_ext_wr; logic [7:0] last_ext_data; logic [2:0] last_ext_addr;

  always #4 clk = ~clk;  // 125 MHz

  assign ext_rd_data = {5'b10100, ext_addr};

  mux_bus_ram_io #(.CE_ACTIVE_HIGH(CE_HI)) u_dut (.*);

  function automatic logic [7:0] ext_expect(input logic [2:0] a);
    return {5'b10100, a};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic latch(input logic io, input logic [7:0] a, input logic ce);
    ale = 1; ad_in = a; io_m = io; ce_pin = ce;
    @(negedge clk); ale = 0;
    @(negedge clk);
  endtask

  task automatic wstrobe(input logic [7:0] d);
    ad_in = d; wr_n = 0;
    @(negedge clk); @(negedge clk);
    wr_n = 1;
    @(negedge clk);
    last_ext_wr = ext_wr; last_ext_data = ext_wdata; last_ext_addr = ext_addr;
    @(negedge clk);
  endtask

  task automatic rstrobe(output logic [7:0] d, output logic oe);
    ad_in = 8'hEE; rd_n = 0;
    @(negedge clk); @(negedge clk);
    d = ad_out; oe = ad_oe; rd_n = 1;
    @(negedge clk);
  endtask

  task automatic mem_wr(input logic [7:0] a, input logic [7:0] d);
    latch(0, a, CE_ON); wstrobe(d); model[a] = d; known[a] = 1;
  endtask

  task automatic io_wr(input logic [7:0] a, input logic [7:0] d);
    latch(1, a, CE_ON); wstrobe(d);
  endtask

  task automatic do_rd(input logic io, input logic [7:0] a);
    latch(io, a, CE_ON); rstrobe(rv, roe);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    check("R10 pa_oe", pa_oe, 0); check("R10 pb_oe", pb_oe, 0);
    check("R10 pc_oe", pc_oe, 0); check("R4 ad_oe idle", ad_oe, 0);

    // R2 R3 memory boundaries
    mem_wr(8'h00, 8'h3C); mem_wr(8'hFF, 8'hC3);
    do_rd(0, 8'h00); check("R3 mem[00]", rv, 8'h3C); check("R3 oe", roe, 1);
    do_rd(0, 8'hFF); check("R3 mem[FF]", rv, 8'hC3);
    // R1 address held although bus moved during strobes
    mem_wr(8'h12, 8'h77);
    do_rd(0, 8'h12); check("R1 held address", rv, 8'h77);
    @(negedge clk); check("R4 oe drops after read", ad_oe, 0);

    // R5 R11 captured enable wins over the live pin
    latch(0, 8'h20, CE_ON); ce_pin = CE_OFF; wstrobe(8'hA1); model[8'h20] = 8'hA1;
    latch(0, 8'h20, CE_OFF); ce_pin = CE_ON; wstrobe(8'h5E);
    latch(0, 8'h20, CE_OFF); ce_pin = CE_ON; rstrobe(rv, roe);
    check("R4 no drive when disabled", roe, 0);
    latch(0, 8'h20, CE_ON); ce_pin = CE_OFF; rstrobe(rv, roe);
    check("R5 enabled write kept, disabled write dropped", rv, 8'hA1);
    check("R11 active level drives", roe, 1);

    // R6 R8 command register
    io_wr(8'h00, 8'h03);
    check("R6 ext_wr cmd", last_ext_wr, 1); check("R6 ext_addr", last_ext_addr, 0);
    check("R6 ext_wdata", last_ext_data, 8'h03);
    check("R8 pa_oe", pa_oe, 8'hFF); check("R8 pb_oe", pb_oe, 8'hFF);
    check("R8 pc_oe in", pc_oe, 0);
    io_wr(8'h01, 8'h5A); check("R6 ext_wr quiet on port", last_ext_wr, 0);
    check("R6 pa_out", pa_out, 8'h5A);
    pa_in = 8'h11;
    do_rd(1, 8'h01); check("R9 port A as output", rv, 8'h5A);
    do_rd(0, 8'h01);
    check("R6 io write leaves memory", rv === 8'h5A ? 1'b0 : 1'b1, 1);
    io_wr(8'h00, 8'h01); pb_in = 8'h96;
    io_wr(8'h02, 8'h44); check("R6 pb_out", pb_out, 8'h44);
    do_rd(1, 8'h02); check("R9 port B as input", rv, 8'h96);
    io_wr(8'h00, 8'h0C); check("R8 pc_oe out", pc_oe, 6'h3F);
    io_wr(8'h03, 8'h2A); do_rd(1, 8'h03); check("R9 port C out", rv, 8'h2A);
    io_wr(8'h00, 8'h04); check("R8 pc mode 01 input", pc_oe, 0);
    pc_in = 6'h15; do_rd(1, 8'h03); check("R9 port C in", rv, 8'h15);
    io_wr(8'h04, 8'hB7);
    check("R6 timer ext_wr", last_ext_wr, 1); check("R6 timer addr", last_ext_addr, 4);
    check("R6 timer data", last_ext_data, 8'hB7);
    do_rd(1, 8'h05); check("R6 timer read", rv, ext_expect(3'd5));
    do_rd(1, 8'h00); check("R6 status read", rv, ext_expect(3'd0));

    // R7 unused I/O space
    io_wr(8'h00, 8'h03);
    io_wr(8'h06, 8'h00); check("R7 no ext_wr at 6", last_ext_wr, 0);
    io_wr(8'h41, 8'h00); check("R7 no ext_wr at 41", last_ext_wr, 0);
    check("R7 pa_oe kept", pa_oe, 8'hFF); check("R7 pa_out kept", pa_out, 8'h5A);
    check("R7 cmd kept", ctrl_word, 8'h03);
    do_rd(1, 8'h06); check("R7 read 6", rv, 0); check("R7 read drives", roe, 1);
    do_rd(1, 8'h41); check("R7 read 41", rv, 0);

    // R10 reset after programming
    rst = 1; @(negedge clk); @(negedge clk); rst = 0; @(negedge clk);
    check("R10 pa_oe", pa_oe, 0); check("R10 pb_oe", pb_oe, 0);
    check("R10 pc_oe", pc_oe, 0); check("R10 pa_out", pa_out, 0);
    pa_in = 8'hD2; do_rd(1, 8'h01); check("R10 port A input", rv, 8'hD2);

    // random memory traffic
    for (int i = 0; i < 120; i++) begin
      logic [7:0] a, d;
      a = 8'($urandom); d = 8'($urandom);
      mem_wr(a, d);
    end
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a;
      a = 8'($urandom);
      if (known[a]) begin
        do_rd(0, a); check("R2 random readback", rv, model[a]);
      end
    end
    // random port B output traffic
    io_wr(8'h00, 8'h02);
    for (int i = 0; i < 10; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      io_wr(8'h02, d); do_rd(1, 8'h02); check("R9 random port B", rv, d);
    end
    finish_run();
  end
endmodule